// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst. The controller issues a column command on `cmd_go` and gives with it a start column, a length code and a wrap-order select. From the next cycle on, the block presents one column per clock on `col_out` and marks it with `beat_valid`. On the final beat of a fixed-length burst it also raises `beat_last`.

The block has two wrap orders. In sequential order the low bits count up and wrap inside an aligned block of the burst length. In interleaved order the low bits of the start column are XORed with the beat index. A full-page length walks the whole row, modulo the column space, until a stop or a new command arrives. Interleaved order has no full-page form, so that combination runs as sequential full page.

A new command may land on any cycle, including the cycle after the previous one, and restarts the walk at its own column. A stop request ends the burst on the next cycle. Every output is a flop that a synchronous active-high reset clears.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `beat_valid`, `beat_last` and `col_out` are all zero.
- R2: When `cmd_go` is sampled high at a clock edge, `beat_valid` is high after that edge and `col_out` equals the sampled `cmd_col`.
- R3: In sequential order (`cmd_ilv`=0) with burst length N, beat k outputs the start column with its low log2(N) bits replaced by (start low bits + k) mod N. The upper bits do not change.
- R4: In interleaved order (`cmd_ilv`=1) with burst length N, beat k outputs the start column with its low log2(N) bits XORed with k.
- R5: `cmd_len` values 0, 1, 2 and 3 select lengths 1, 2, 4 and 8. `beat_last` is high exactly on beat N-1, only together with `beat_valid`, and `beat_valid` falls on the cycle after the last beat.
- R6: Any `cmd_len` with bit 2 set selects full page. Beat k outputs (start + k) mod 256, the burst passes beyond 256 beats, and `beat_last` never rises.
- R7: A full-page length with `cmd_ilv`=1 produces the same column stream as sequential full page.
- R8: `cmd_stop` sampled high without `cmd_go` drops `beat_valid` and `beat_last` after that edge. A stop while idle leaves the outputs invalid.
- R9: `cmd_go` during a running burst, including on consecutive cycles and together with `cmd_stop`, restarts the sequence at the new column on the next cycle.
- R10: A length-1 burst shows exactly one valid beat, and `beat_last` is high on that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_go | input | 1 | Column command: starts or restarts a burst |
| cmd_stop | input | 1 | Ends the running burst |
| cmd_col | input | 8 | Start column of the command |
| cmd_len | input | 3 | Length code: 0..3 select 1/2/4/8 beats; bit 2 set selects full page |
| cmd_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| col_out | output | 8 | Column of the current beat |
| beat_valid | output | 1 | Current beat is valid |
| beat_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Some rules are checked by the assertions on every cycle. A command loads its column on the next cycle. A stop empties the pipe. `beat_last` never appears without `beat_valid`. A burst ends right after its last beat. Between stops, a running burst that is not at its last beat stays valid. The bench scenarios check the column values themselves: the wrap inside an aligned block, the XOR order, the modulo-256 walk in full page, and the folding of interleaved full page onto sequential order. They also check what interrupts and back-to-back commands do to the stream over several cycles.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

  // Length code: bit 2 selects full page, bits 1:0 give log2 of the beat count.
  localparam int LEN_CODE_W = 3;
  localparam int LOG_W      = 2;

  typedef struct packed {
    logic [LOG_W-1:0] lenlog;  // log2(burst length) for fixed bursts
    logic             full;    // full-page walk
    logic             ilv;     // interleaved order (never set with full)
  } walk_mode_t;

  function automatic walk_mode_t decode_mode(input logic [LEN_CODE_W-1:0] code,
                                             input logic ilv_req);
    walk_mode_t m;
    m.full   = code[LEN_CODE_W-1];
    m.lenlog = code[LOG_W-1:0];
    m.ilv    = ilv_req & ~code[LEN_CODE_W-1];
    return m;
  endfunction

endpackage

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  walk_mode_t       mode,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  // Bit i belongs to the wrapping field when i < log2(N), or always in full page.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign wrap_mask[i] = mode.full | (i < int'(mode.lenlog));
  end

  assign sum     = base + beat;
  assign seq_col = (base & ~wrap_mask) | (sum & wrap_mask);
  assign ilv_col = base ^ (beat & wrap_mask);
  assign col     = mode.ilv ? ilv_col : seq_col;

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic                  halt,
  input  logic [COL_W-1:0]      go_col,
  input  logic [LEN_CODE_W-1:0] go_len,
  input  logic                  go_ilv,
  output logic                  nxt_act,
  output logic                  nxt_last,
  output logic [COL_W-1:0]      nxt_beat,
  output logic [COL_W-1:0]      nxt_base,
  output walk_mode_t            nxt_mode
);

  logic             act_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  walk_mode_t       mode_q;
  logic             cur_last;

  function automatic logic [COL_W-1:0] final_idx(input logic [LOG_W-1:0] lg);
    logic [COL_W-1:0] one;
    one = COL_W'(1);
    return (one << lg) - one;
  endfunction

  assign cur_last = act_q & ~mode_q.full & (beat_q == final_idx(mode_q.lenlog));

  always_comb begin
    nxt_act  = act_q;
    nxt_beat = beat_q;
    nxt_base = base_q;
    nxt_mode = mode_q;
    if (go) begin
      nxt_act  = 1'b1;
      nxt_beat = '0;
      nxt_base = go_col;
      nxt_mode = decode_mode(go_len, go_ilv);
    end else if (halt || cur_last) begin
      nxt_act  = 1'b0;
    end else if (act_q) begin
      nxt_beat = beat_q + COL_W'(1);
    end
    nxt_last = nxt_act & ~nxt_mode.full & (nxt_beat == final_idx(nxt_mode.lenlog));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      mode_q <= '0;
    end else begin
      act_q  <= nxt_act;
      beat_q <= nxt_beat;
      base_q <= nxt_base;
      mode_q <= nxt_mode;
    end
  end

  // R6: a full-page walk keeps running while neither stop nor command arrives
  a_r6_full_runs_on: assert property (@(posedge clk) disable iff (rst)
    (act_q && mode_q.full && !go && !halt) |=> act_q);

  // R8: a stop without a command clears the burst
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (halt && !go) |=> !act_q);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_go,
  input  logic                  cmd_stop,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic [LEN_CODE_W-1:0] cmd_len,
  input  logic                  cmd_ilv,
  output logic [COL_W-1:0]      col_out,
  output logic                  beat_valid,
  output logic                  beat_last
);

  logic             n_act;
  logic             n_last;
  logic [COL_W-1:0] n_beat;
  logic [COL_W-1:0] n_base;
  walk_mode_t       n_mode;
  logic [COL_W-1:0] n_col;

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go       (cmd_go),
    .halt     (cmd_stop),
    .go_col   (cmd_col),
    .go_len   (cmd_len),
    .go_ilv   (cmd_ilv),
    .nxt_act  (n_act),
    .nxt_last (n_last),
    .nxt_beat (n_beat),
    .nxt_base (n_base),
    .nxt_mode (n_mode)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_gen (
    .base (n_base),
    .beat (n_beat),
    .mode (n_mode),
    .col  (n_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_out    <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
    end else begin
      col_out    <= n_col;
      beat_valid <= n_act;
      beat_last  <= n_last;
    end
  end

  // R2: a command shows its own column on the next cycle
  a_r2_go_loads_col: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (beat_valid && col_out == $past(cmd_col)));

  // R5: last-beat only flags a valid beat
  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  // R5: the burst ends right after its last beat unless a new command arrives
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !cmd_go) |=> !beat_valid);

  // R8: stop empties the output
  a_r8_stop_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && !cmd_go) |=> (!beat_valid && !beat_last));

  // R3: a running burst that is not on its last beat keeps going
  a_r3_burst_continues: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last && !cmd_go && !cmd_stop) |=> beat_valid);

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_go = 1'b0;
  logic       cmd_stop = 1'b0;
  logic [7:0] cmd_col = '0;
  logic [2:0] cmd_len = '0;
  logic       cmd_ilv = 1'b0;
  logic [7:0] col_out;
  logic       beat_valid;
  logic       beat_last;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_col_seq u_dut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_stop(cmd_stop),
    .cmd_col(cmd_col), .cmd_len(cmd_len), .cmd_ilv(cmd_ilv),
    .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
  );

  // Vector: start col, len code, ilv, beat count, expected column of beat 1
  localparam int NV = 10;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {8'h35, 3'd2, 1'b0, 4'd4, 8'h36},
    {8'h35, 3'd2, 1'b1, 4'd4, 8'h34},
    {8'h1D, 3'd3, 1'b0, 4'd8, 8'h1E},
    {8'h1D, 3'd3, 1'b1, 4'd8, 8'h1C},
    {8'h07, 3'd1, 1'b0, 4'd2, 8'h06},
    {8'h07, 3'd1, 1'b1, 4'd2, 8'h06},
    {8'hFF, 3'd3, 1'b0, 4'd8, 8'hF8},
    {8'hA0, 3'd0, 1'b0, 4'd1, 8'hA0},
    {8'h42, 3'd3, 1'b1, 4'd8, 8'h43},
    {8'h00, 3'd2, 1'b0, 4'd4, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model(input int s, input int len, input bit ilv, input int k);
    int n, blk, lo;
    if (len >= 4) return (s + k) % 256;
    n   = 1 << len;
    blk = (s / n) * n;
    lo  = s % n;
    if (ilv) return blk + (lo ^ k);
    return blk + ((lo + k) % n);
  endfunction

  // Called right after a negedge: drives a command for one edge, returns at the next negedge.
  task automatic issue(input logic [7:0] c, input logic [2:0] l, input bit i, input bit stp);
    cmd_go = 1'b1; cmd_stop = stp; cmd_col = c; cmd_len = l; cmd_ilv = i;
    @(negedge clk);
    cmd_go = 1'b0; cmd_stop = 1'b0;
  endtask

  task automatic walk(input int s, input int len, input bit ilv, input int beats, input string req);
    for (int k = 0; k < beats; k++) begin
      chk(beat_valid == 1'b1, req, beat_valid, 1);
      chk(col_out == 8'(model(s, len, ilv, k)), req, col_out, model(s, len, ilv, k));
      chk(beat_last == (len < 4 && k == beats - 1), req, beat_last, (len < 4 && k == beats - 1));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(beat_valid == 0 && beat_last == 0 && col_out == 0, "R1", {beat_valid, beat_last, col_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(beat_valid == 0 && col_out == 0, "R1", {beat_valid, col_out}, 0);

    // Table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      logic [23:0] e;
      e = VEC[v];
      issue(e[23:16], e[15:13], e[12], 1'b0);
      chk(col_out == e[23:16], "R2", col_out, e[23:16]);
      if (e[11:8] > 1) begin
        // beat 1 appears one cycle after beat 0
        @(negedge clk);
        chk(col_out == e[7:0], e[12] ? "R4" : "R3", col_out, e[7:0]);
        // restart same burst and walk it fully
        issue(e[23:16], e[15:13], e[12], 1'b0);
      end
      walk(e[23:16], e[15:13], e[12], e[11:8], e[12] ? "R4" : "R5");
      chk(beat_valid == 0, (e[11:8] == 1) ? "R10" : "R5", beat_valid, 0);
    end

    // R6 R7: interleave + full page runs as sequential, wraps past 255, no last
    issue(8'hFD, 3'b100, 1'b1, 1'b0);
    walk(8'hFD, 4, 1'b0, 300, "R7");
    chk(beat_valid == 1, "R6", beat_valid, 1);
    chk(col_out == 8'((8'hFD + 300) % 256), "R6", col_out, (8'hFD + 300) % 256);
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    chk(beat_valid == 0 && beat_last == 0, "R8", {beat_valid, beat_last}, 0);

    // R8: stop mid-burst
    issue(8'h20, 3'd3, 1'b0, 1'b0);
    chk(col_out == 8'h20, "R2", col_out, 8'h20);
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    chk(beat_valid == 0, "R8", beat_valid, 0);
    // R8: stop while idle has no effect
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    chk(beat_valid == 0 && beat_last == 0, "R8", {beat_valid, beat_last}, 0);
    @(negedge clk);
    chk(beat_valid == 0, "R8", beat_valid, 0);

    // R9: interrupt mid-burst with a new interleaved command
    issue(8'h10, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    chk(col_out == 8'h11, "R3", col_out, 8'h11);
    issue(8'h80, 3'd2, 1'b1, 1'b0);
    walk(8'h80, 2, 1'b1, 4, "R9");
    chk(beat_valid == 0, "R9", beat_valid, 0);

    // R9: back-to-back commands on consecutive cycles
    cmd_go = 1'b1; cmd_len = 3'd3; cmd_ilv = 1'b0; cmd_col = 8'h05;
    @(negedge clk);
    chk(col_out == 8'h05 && beat_valid, "R9", col_out, 8'h05);
    cmd_col = 8'h09;
    @(negedge clk);
    chk(col_out == 8'h09 && beat_valid, "R9", col_out, 8'h09);
    cmd_col = 8'h0C;
    @(negedge clk);
    cmd_go = 1'b0;
    walk(8'h0C, 3, 1'b0, 8, "R9");

    // R9: command together with stop: command wins
    issue(8'h60, 3'd3, 1'b0, 1'b0);
    issue(8'h33, 3'd1, 1'b0, 1'b1);
    walk(8'h33, 1, 1'b0, 2, "R9");
    chk(beat_valid == 0, "R9", beat_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule